// File: doc/BRIEF.md
# Register Wakeup Dependency Scoreboard

This block keeps one ready bit for each physical register of an out-of-order core, together with a record of which issue-queue slots are waiting on each register. When rename names an instruction as the producer of a destination register, the ready bit drops. When an instruction enters the issue queue, each source that is still pending ties its slot to the source register's waiting set. Sources that are already available are marked satisfied immediately.

When a producer completes, every slot in that register's waiting set gets that operand marked available. The set is then emptied, and a one-cycle wake pulse is given for each affected slot. A slot can be removed at any time with a per-slot clear, which takes it out of every waiting set it belongs to. Tags at or above the physical register count name untracked registers. The scoreboard passes these through without recording anything. A slot becomes issue-eligible once it is occupied and all of its valid sources are available.

Top module: `regwake_scoreboard`

## Requirements
- R1: An allocate with a tracked tag (below 16) clears that register's bit in `reg_ready`, which is visible after the next rising edge. If an allocate and a completion name the same tag in the same cycle, the allocate wins.
- R2: An allocate whose tag is 16 or above leaves `reg_ready` unchanged and never raises `alloc_err`.
- R3: A valid source whose tag is 16 or above never keeps its slot from becoming issue-eligible.
- R4: A valid source whose register is ready at insert time is satisfied at once. An inserted slot whose valid sources are all ready shows in `issue_ready` right after the insert edge. An invalid source is ignored.
- R5: An allocate of a tracked tag whose waiting set holds at least one slot makes `alloc_err` high for the one cycle after that edge.
- R6: A completion of a tracked tag sets its ready bit. In the cycle after the completion edge, `wake_mask` bit s is high for exactly those slots s that were waiting on that tag. A slot that was waiting on the tag with both sources gets a single bit. Any slot whose sources are now all ready shows in `issue_ready`.
- R7: A clear of slot s removes it from every waiting set. A later completion gives that slot no wake pulse, and a later allocate of the same tag raises no `alloc_err`.
- R8: A completion and an insert that name the same tag in the same cycle make the insert see the register as ready. No later wake pulse follows for that source.
- R9: After reset every `reg_ready` bit is 1, and `wake_mask`, `issue_ready` and `alloc_err` are 0. Bit s of `issue_ready` is 1 exactly when slot s is occupied and none of its valid sources is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Producer allocate strobe |
| alloc_tag | input | 5 | Destination tag being allocated |
| ins_valid | input | 1 | Consumer insert strobe |
| ins_slot | input | 3 | Issue-queue slot being filled |
| src0_valid | input | 1 | First source is used |
| src0_tag | input | 5 | First source tag |
| src1_valid | input | 1 | Second source is used |
| src1_tag | input | 5 | Second source tag |
| done_valid | input | 1 | Producer completion strobe |
| done_tag | input | 5 | Completed destination tag |
| clr_valid | input | 1 | Slot clear strobe |
| clr_slot | input | 3 | Slot to clear |
| reg_ready | output | 16 | Ready bit per tracked register |
| wake_mask | output | 8 | One-cycle pulse per slot woken by a completion |
| issue_ready | output | 8 | Slot occupied with all valid sources ready |
| alloc_err | output | 1 | Allocate hit a register with a non-empty waiting set |

## Verification
Damage to a waiting set shows up one cycle after the next completion of that tag. A lost link leaves a missing `wake_mask` bit, and the slot never reaches `issue_ready`. A stale link gives an extra wake bit, and it also gives a false `alloc_err` on the next allocate of that tag. A wrong per-slot pending bit shows in `issue_ready` right after the insert or completion edge. A wrong ready bit shows directly on `reg_ready`. It also shows one insert later, when a consumer is linked or satisfied in error.

// File: rtl/regwake_pkg.sv
package regwake_pkg;
    parameter int unsigned SB_NUM_PREGS = 16;
    parameter int unsigned SB_TAG_W     = 5;
    parameter int unsigned SB_NUM_SLOTS = 8;
    parameter int unsigned SB_NUM_SRC   = 2;
    localparam int unsigned SB_REG_W    = $clog2(SB_NUM_PREGS);
    localparam int unsigned SB_SLOT_W   = $clog2(SB_NUM_SLOTS);

    typedef logic [SB_TAG_W-1:0]     tag_t;
    typedef logic [SB_REG_W-1:0]     reg_idx_t;
    typedef logic [SB_SLOT_W-1:0]    slot_t;
    typedef logic [SB_NUM_SLOTS-1:0] slot_vec_t;
    typedef logic [SB_NUM_PREGS-1:0] reg_vec_t;

    typedef struct packed {
        logic vld;
        tag_t tag;
    } tag_req_t;

    typedef struct packed {
        logic  vld;
        slot_t slot;
    } slot_req_t;

    // Tags at or above the register count are not renamed registers.
    function automatic logic tag_tracked(tag_t t);
        return 32'(t) < SB_NUM_PREGS;
    endfunction

    function automatic reg_idx_t tag_index(tag_t t);
        return t[SB_REG_W-1:0];
    endfunction

    function automatic reg_vec_t tag_onehot(tag_req_t r);
        reg_vec_t v;
        v = '0;
        if (r.vld && tag_tracked(r.tag)) v[tag_index(r.tag)] = 1'b1;
        return v;
    endfunction

    function automatic slot_vec_t slot_onehot(slot_req_t r);
        slot_vec_t v;
        v = '0;
        if (r.vld) v[r.slot] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/regwake_ready_bits.sv
module regwake_ready_bits
    import regwake_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_vec_t alloc_oh,
    input  reg_vec_t done_oh,
    output reg_vec_t ready_q
);
    // Allocate has priority over a completion of the same register.
    always_ff @(posedge clk) begin
        if (rst) ready_q <= '1;
        else     ready_q <= (ready_q | done_oh) & ~alloc_oh;
    end
endmodule

// File: rtl/regwake_chain_matrix.sv
module regwake_chain_matrix
    import regwake_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  reg_vec_t  done_oh,
    input  slot_vec_t drop_mask,
    input  slot_vec_t link_row [SB_NUM_PREGS],
    output slot_vec_t chain_q  [SB_NUM_PREGS]
);
    for (genvar r = 0; r < SB_NUM_PREGS; r++) begin : g_row
        slot_vec_t row_next;
        always_comb begin
            row_next = chain_q[r] & ~drop_mask;
            if (done_oh[r]) row_next = '0;
            row_next = row_next | link_row[r];
        end
        always_ff @(posedge clk) begin
            if (rst) chain_q[r] <= '0;
            else     chain_q[r] <= row_next;
        end
    end
endmodule

// File: rtl/regwake_slot_table.sv
module regwake_slot_table
    import regwake_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  slot_vec_t             ins_oh,
    input  slot_vec_t             clr_oh,
    input  tag_t                  src_tag  [SB_NUM_SRC],
    input  logic [SB_NUM_SRC-1:0] src_pend,
    input  tag_req_t              done_r,
    output slot_vec_t             eligible
);
    logic done_trk;
    assign done_trk = done_r.vld && tag_tracked(done_r.tag);

    for (genvar s = 0; s < SB_NUM_SLOTS; s++) begin : g_slot
        logic                  occ_q;
        logic [SB_NUM_SRC-1:0] pend_q;
        tag_t                  tag_q [SB_NUM_SRC];

        always_ff @(posedge clk) begin
            if (rst) begin
                occ_q  <= 1'b0;
                pend_q <= '0;
                for (int k = 0; k < SB_NUM_SRC; k++) tag_q[k] <= '0;
            end else if (ins_oh[s]) begin
                occ_q  <= 1'b1;
                pend_q <= src_pend;
                for (int k = 0; k < SB_NUM_SRC; k++) tag_q[k] <= src_tag[k];
            end else if (clr_oh[s]) begin
                occ_q  <= 1'b0;
                pend_q <= '0;
            end else if (done_trk) begin
                for (int k = 0; k < SB_NUM_SRC; k++)
                    if (tag_q[k] == done_r.tag) pend_q[k] <= 1'b0;
            end
        end

        assign eligible[s] = occ_q && (pend_q == '0);
    end
endmodule

// File: rtl/regwake_scoreboard.sv
module regwake_scoreboard
    import regwake_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    alloc_valid,
    input  logic [SB_TAG_W-1:0]     alloc_tag,
    input  logic                    ins_valid,
    input  logic [SB_SLOT_W-1:0]    ins_slot,
    input  logic                    src0_valid,
    input  logic [SB_TAG_W-1:0]     src0_tag,
    input  logic                    src1_valid,
    input  logic [SB_TAG_W-1:0]     src1_tag,
    input  logic                    done_valid,
    input  logic [SB_TAG_W-1:0]     done_tag,
    input  logic                    clr_valid,
    input  logic [SB_SLOT_W-1:0]    clr_slot,
    output logic [SB_NUM_PREGS-1:0] reg_ready,
    output logic [SB_NUM_SLOTS-1:0] wake_mask,
    output logic [SB_NUM_SLOTS-1:0] issue_ready,
    output logic                    alloc_err
);
    tag_req_t  alloc_r, done_r;
    tag_req_t  src_r [SB_NUM_SRC];
    tag_t      src_tag [SB_NUM_SRC];
    reg_vec_t  alloc_oh, done_oh, ready_q;
    slot_vec_t ins_oh, clr_oh, drop_mask;
    slot_vec_t link_row [SB_NUM_PREGS];
    slot_vec_t chain_q  [SB_NUM_PREGS];
    logic [SB_NUM_SRC-1:0] src_link;
    slot_vec_t wake_q;
    logic      err_q;

    assign alloc_r  = '{vld: alloc_valid, tag: alloc_tag};
    assign done_r   = '{vld: done_valid,  tag: done_tag};
    assign src_r[0] = '{vld: src0_valid,  tag: src0_tag};
    assign src_r[1] = '{vld: src1_valid,  tag: src1_tag};
    assign alloc_oh = tag_onehot(alloc_r);
    assign done_oh  = tag_onehot(done_r);
    assign ins_oh   = slot_onehot('{vld: ins_valid, slot: ins_slot});
    assign clr_oh   = slot_onehot('{vld: clr_valid, slot: clr_slot});
    assign drop_mask = ins_oh | clr_oh;

    // A source links only when it is tracked and still pending once
    // same-cycle completion and allocate are taken into account.
    for (genvar k = 0; k < SB_NUM_SRC; k++) begin : g_src
        reg_idx_t idx;
        logic     now_ready;
        assign idx       = tag_index(src_r[k].tag);
        assign now_ready = (ready_q[idx] | done_oh[idx]) & ~alloc_oh[idx];
        assign src_link[k] = ins_valid && src_r[k].vld &&
                             tag_tracked(src_r[k].tag) && !now_ready;
        assign src_tag[k]  = src_r[k].tag;
    end

    for (genvar r = 0; r < SB_NUM_PREGS; r++) begin : g_link
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int k = 0; k < SB_NUM_SRC; k++)
                if (src_link[k] && 32'(tag_index(src_r[k].tag)) == r) hit = 1'b1;
        end
        assign link_row[r] = hit ? ins_oh : '0;
    end

    regwake_ready_bits u_ready (
        .clk      (clk),
        .rst      (rst),
        .alloc_oh (alloc_oh),
        .done_oh  (done_oh),
        .ready_q  (ready_q)
    );

    regwake_chain_matrix u_chain (
        .clk       (clk),
        .rst       (rst),
        .done_oh   (done_oh),
        .drop_mask (drop_mask),
        .link_row  (link_row),
        .chain_q   (chain_q)
    );

    regwake_slot_table u_slots (
        .clk      (clk),
        .rst      (rst),
        .ins_oh   (ins_oh),
        .clr_oh   (clr_oh),
        .src_tag  (src_tag),
        .src_pend (src_link),
        .done_r   (done_r),
        .eligible (issue_ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_q <= '0;
            err_q  <= 1'b0;
        end else begin
            wake_q <= (|done_oh) ? (chain_q[tag_index(done_tag)] & ~clr_oh) : '0;
            err_q  <= (|alloc_oh) && (|chain_q[tag_index(alloc_tag)]) &&
                      !(done_valid && done_tag == alloc_tag);
        end
    end

    assign reg_ready = ready_q;
    assign wake_mask = wake_q;
    assign alloc_err = err_q;
endmodule

// File: rtl/regwake_chk.sv
module regwake_chk
    import regwake_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic                    alloc_valid,
    input logic [SB_TAG_W-1:0]     alloc_tag,
    input logic                    done_valid,
    input logic [SB_TAG_W-1:0]     done_tag,
    input logic [SB_NUM_PREGS-1:0] reg_ready,
    input logic [SB_NUM_SLOTS-1:0] wake_mask,
    input logic [SB_NUM_SLOTS-1:0] issue_ready,
    input logic                    alloc_err
);
    localparam logic [SB_TAG_W-1:0] LIMIT = SB_TAG_W'(SB_NUM_PREGS);

    a_r1_alloc_clears: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_tag < LIMIT) |=>
            !reg_ready[$past(alloc_tag[SB_REG_W-1:0])]);

    a_r2_untracked_inert: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && alloc_tag >= LIMIT && !done_valid) |=>
            (reg_ready == $past(reg_ready)) && !alloc_err);

    a_r6_done_sets: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_tag < LIMIT &&
         !(alloc_valid && alloc_tag == done_tag)) |=>
            reg_ready[$past(done_tag[SB_REG_W-1:0])]);

    a_r6_wake_after_done: assert property (@(posedge clk) disable iff (rst)
        (wake_mask != '0) |-> $past(done_valid && done_tag < LIMIT));

    a_r9_wake_was_blocked: assert property (@(posedge clk) disable iff (rst)
        (wake_mask & $past(issue_ready)) == '0);

    a_r5_err_follows_alloc: assert property (@(posedge clk) disable iff (rst)
        alloc_err |-> $past(alloc_valid && alloc_tag < LIMIT));
endmodule

bind regwake_scoreboard regwake_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .alloc_valid (alloc_valid),
    .alloc_tag   (alloc_tag),
    .done_valid  (done_valid),
    .done_tag    (done_tag),
    .reg_ready   (reg_ready),
    .wake_mask   (wake_mask),
    .issue_ready (issue_ready),
    .alloc_err   (alloc_err)
);

// File: tb/regwake_scoreboard_tb.sv
module regwake_scoreboard_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alloc_valid = 0, ins_valid = 0, src0_valid = 0, src1_valid = 0;
    logic       done_valid = 0, clr_valid = 0;
    logic [4:0] alloc_tag = 0, src0_tag = 0, src1_tag = 0, done_tag = 0;
    logic [2:0] ins_slot = 0, clr_slot = 0;
    logic [15:0] reg_ready;
    logic [7:0]  wake_mask, issue_ready;
    logic        alloc_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        string       req;
        logic [15:0] ready;
        logic [7:0]  wake;
        logic [7:0]  elig;
        logic        err;
    } exp_t;
    exp_t exp_q[$];

    // Reference model state, built from the requirements.
    logic [15:0] m_ready;
    logic [7:0]  m_occ, m_p0, m_p1;
    logic [4:0]  m_t0 [8];
    logic [4:0]  m_t1 [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    regwake_scoreboard dut_i (
        .clk(clk), .rst(rst),
        .alloc_valid(alloc_valid), .alloc_tag(alloc_tag),
        .ins_valid(ins_valid), .ins_slot(ins_slot),
        .src0_valid(src0_valid), .src0_tag(src0_tag),
        .src1_valid(src1_valid), .src1_tag(src1_tag),
        .done_valid(done_valid), .done_tag(done_tag),
        .clr_valid(clr_valid), .clr_slot(clr_slot),
        .reg_ready(reg_ready), .wake_mask(wake_mask),
        .issue_ready(issue_ready), .alloc_err(alloc_err)
    );

    function automatic bit trk(logic [4:0] t);
        return t < 5'd16;
    endfunction

    task automatic step(input string req,
                        input bit av, input int at,
                        input bit iv, input int is,
                        input bit s0v, input int s0t,
                        input bit s1v, input int s1t,
                        input bit dv, input int dt,
                        input bit cv, input int cs);
        exp_t e;
        logic [4:0] a5, d5, t0, t1;
        bit eff0, eff1, hit;
        a5 = 5'(at); d5 = 5'(dt); t0 = 5'(s0t); t1 = 5'(s1t);
        alloc_valid = av; alloc_tag = a5;
        ins_valid = iv; ins_slot = 3'(is);
        src0_valid = s0v; src0_tag = t0;
        src1_valid = s1v; src1_tag = t1;
        done_valid = dv; done_tag = d5;
        clr_valid = cv; clr_slot = 3'(cs);
        eff0 = !trk(t0) || ((m_ready[t0[3:0]] || (dv && d5 == t0)) && !(av && a5 == t0));
        eff1 = !trk(t1) || ((m_ready[t1[3:0]] || (dv && d5 == t1)) && !(av && a5 == t1));
        e.req = req;
        e.wake = '0;
        e.err = 1'b0;
        for (int s = 0; s < 8; s++) begin
            if (dv && trk(d5) && m_occ[s] &&
                ((m_p0[s] && m_t0[s] == d5) || (m_p1[s] && m_t1[s] == d5)) &&
                !(cv && cs == s))
                e.wake[s] = 1'b1;
            hit = m_occ[s] && ((m_p0[s] && m_t0[s] == a5) || (m_p1[s] && m_t1[s] == a5));
            if (av && trk(a5) && hit && !(dv && d5 == a5)) e.err = 1'b1;
        end
        if (dv && trk(d5)) m_ready[d5[3:0]] = 1'b1;
        if (av && trk(a5)) m_ready[a5[3:0]] = 1'b0;
        for (int s = 0; s < 8; s++) begin
            if (iv && is == s) begin
                m_occ[s] = 1'b1;
                m_p0[s] = s0v && !eff0; m_t0[s] = t0;
                m_p1[s] = s1v && !eff1; m_t1[s] = t1;
            end else if (cv && cs == s) begin
                m_occ[s] = 1'b0; m_p0[s] = 1'b0; m_p1[s] = 1'b0;
            end else if (dv && trk(d5)) begin
                if (m_t0[s] == d5) m_p0[s] = 1'b0;
                if (m_t1[s] == d5) m_p1[s] = 1'b0;
            end
        end
        e.ready = m_ready;
        e.elig = m_occ & ~m_p0 & ~m_p1;
        exp_q.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: compares each expected item after the edge it belongs to.
    always @(posedge clk) begin
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            #1;
            e = exp_q.pop_front();
            checks++;
            if (reg_ready !== e.ready || wake_mask !== e.wake ||
                issue_ready !== e.elig || alloc_err !== e.err) begin
                errors++;
                $display("FAIL %s: ready=%h wake=%b elig=%b err=%b expected ready=%h wake=%b elig=%b err=%b",
                         e.req, reg_ready, wake_mask, issue_ready, alloc_err,
                         e.ready, e.wake, e.elig, e.err);
            end
        end
    end

    initial begin
        m_ready = '1; m_occ = '0; m_p0 = '0; m_p1 = '0;
        for (int s = 0; s < 8; s++) begin m_t0[s] = '0; m_t1[s] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        //      req   av at  iv is s0v s0t s1v s1t dv dt  cv cs
        step("R9", 0, 0,  0, 0, 0, 0,  0, 0,  0, 0,  0, 0); // reset state
        step("R1", 1, 3,  0, 0, 0, 0,  0, 0,  0, 0,  0, 0);
        step("R2", 1, 20, 0, 0, 0, 0,  0, 0,  0, 0,  0, 0);
        step("R3", 0, 0,  1, 0, 1, 3,  1, 20, 0, 0,  0, 0); // untracked src1 not pending
        step("R4", 0, 0,  1, 1, 1, 5,  0, 3,  0, 0,  0, 0); // ready src, invalid src1
        step("R5", 1, 3,  0, 0, 0, 0,  0, 0,  0, 0,  0, 0); // slot0 waits on 3
        step("R6", 0, 0,  0, 0, 0, 0,  0, 0,  1, 3,  0, 0); // wake slot0
        step("R1", 1, 7,  0, 0, 0, 0,  0, 0,  0, 0,  0, 0);
        step("R1", 1, 8,  0, 0, 0, 0,  0, 0,  0, 0,  0, 0);
        step("R6", 0, 0,  1, 2, 1, 7,  1, 8,  0, 0,  0, 0);
        step("R6", 0, 0,  0, 0, 0, 0,  0, 0,  1, 7,  0, 0); // one operand left
        step("R6", 0, 0,  0, 0, 0, 0,  0, 0,  1, 8,  0, 0); // now eligible
        step("R6", 1, 9,  0, 0, 0, 0,  0, 0,  0, 0,  0, 0);
        step("R6", 0, 0,  1, 3, 1, 9,  1, 9,  0, 0,  0, 0);
        step("R6", 0, 0,  0, 0, 0, 0,  0, 0,  1, 9,  0, 0); // single wake bit
        step("R8", 1, 10, 0, 0, 0, 0,  0, 0,  0, 0,  0, 0);
        step("R8", 0, 0,  1, 4, 1, 10, 0, 0,  1, 10, 0, 0); // forwarded completion
        step("R8", 0, 0,  0, 0, 0, 0,  0, 0,  1, 10, 0, 0); // no later wake
        step("R7", 1, 11, 0, 0, 0, 0,  0, 0,  0, 0,  0, 0);
        step("R7", 0, 0,  1, 5, 1, 11, 0, 0,  0, 0,  0, 0);
        step("R7", 0, 0,  0, 0, 0, 0,  0, 0,  0, 0,  1, 5);
        step("R7", 0, 0,  0, 0, 0, 0,  0, 0,  1, 11, 0, 0); // no wake for cleared slot
        step("R7", 1, 11, 0, 0, 0, 0,  0, 0,  0, 0,  0, 0); // no error after clear
        step("R2", 1, 25, 0, 0, 0, 0,  0, 0,  0, 0,  0, 0);
        step("R9", 0, 0,  0, 0, 0, 0,  0, 0,  0, 0,  1, 0); // clear drops eligibility
        step("R9", 0, 0,  0, 0, 0, 0,  0, 0,  0, 0,  0, 0);
        @(posedge clk);
        @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule